// File: doc/BRIEF.md
# Magic Packet Wake Detector

This block watches one received Ethernet frame at a time as a byte stream and raises a sticky wake flag when the frame is a magic packet addressed to this station. Each beat carries one byte on `rx_byte` with `rx_valid`. `rx_sof` marks the first destination byte and `rx_eof` marks the last byte of the frame. The first six bytes form the destination address. Every byte after them is searched for the wake pattern. The pattern is six consecutive 0xFF bytes followed by sixteen back-to-back copies of the 48-bit station address.

Two OR-ed relaxation bits control the destination check. One is a plain input. The other is held in a register that only power-on reset clears. When both bits are 0, the destination must equal the station address. When either bit is 1, any unicast, multicast or broadcast destination passes. The payload rule never changes. Detection counts only while the detector is armed. It is armed either by the pin-enable bit together with a low power-good input, or by the software enable bit.

The parser has five states:

| State | Role |
|-------|------|
| `ST_IDLE` | Waits for a start-of-frame beat. |
| `ST_DEST` | Takes in destination bytes. |
| `ST_SYNC` | Counts consecutive 0xFF bytes. |
| `ST_COPY` | Compares bytes against the station address, copy by copy. |
| `ST_SKIP` | Ignores the rest of the frame after a completed pattern. |

The parser moves between states as follows:

| From | To | Cause |
|------|----|-------|
| any | `ST_DEST` | start-of-frame beat |
| `ST_DEST` | `ST_SYNC` | sixth destination byte |
| `ST_SYNC` | `ST_COPY` | sixth 0xFF in a row |
| `ST_COPY` | `ST_SKIP` | last byte of the sixteenth copy |
| `ST_COPY` | `ST_SYNC` | mismatched byte |
| any | `ST_IDLE` | end-of-frame beat or soft reset |

Top module: `wol_magic_detect`

## Requirements
- R1: While `por_n` is low and on the first cycle after it rises, `wake_flag` and `ext_relax` are 0.
- R2: With `relax_base` and `ext_relax` both 0, a frame sets the flag only if its first six bytes equal `station_addr` in wire order. Byte 0 on the wire is `station_addr[7:0]` and byte 5 is `station_addr[47:40]`. A wrong unicast or broadcast destination leaves the flag at 0.
- R3: If either relaxation bit is 1, a frame with any destination (unicast, multicast 01-00-5E-…, broadcast FF-…) sets the flag when its payload holds the pattern.
- R4: The payload pattern is six 0xFF bytes, then sixteen consecutive copies of the station address, each copy in wire order. Fifteen copies do not set the flag.
- R5: A byte that breaks a copy sends the search back to sync counting. If that byte is 0xFF, it counts as the first byte of a new sync run. Extra 0xFF bytes between the sync run and the first copy are allowed.
- R6: `wake_flag` rises at the clock edge that takes in the last byte of the sixteenth copy, and only if `wake_mode` is 1 on that beat.
- R7: `wake_mode` = (`pin_en` AND NOT `pwr_good`) OR `sw_en`, combinationally.
- R8: An end-of-frame beat before the pattern completes abandons the search without setting the flag. Bytes that arrive after that without a new start-of-frame are ignored.
- R9: `wake_flag` stays 1 until `match_clr` is pulsed, and a pulse of `match_clr` clears it. A new detection on the same cycle wins over the clear.
- R10: `ext_relax` loads `ext_relax_din` when `ext_relax_wr` is 1 and otherwise holds. `soft_rst` leaves it and the flag alone, but abandons any frame in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on / hardware reset, active low |
| soft_rst | input | 1 | Synchronous soft reset of the frame parser |
| station_addr | input | 48 | Station address, bits [7:0] sent first |
| relax_base | input | 1 | Relaxation bit that accepts any destination |
| ext_relax_wr | input | 1 | Write strobe for the extended relaxation bit |
| ext_relax_din | input | 1 | Value written to the extended relaxation bit |
| pin_en | input | 1 | Allows the power-good input to arm detection |
| pwr_good | input | 1 | Power-good input; low arms detection when `pin_en` is set |
| sw_en | input | 1 | Software enable that arms detection |
| rx_valid | input | 1 | Byte strobe |
| rx_sof | input | 1 | First byte of a frame, qualified by `rx_valid` |
| rx_eof | input | 1 | Last byte of a frame, qualified by `rx_valid` |
| rx_byte | input | 8 | Received byte |
| match_clr | input | 1 | Clears the wake flag |
| wake_mode | output | 1 | Detector armed |
| ext_relax | output | 1 | Extended relaxation bit |
| wake_flag | output | 1 | Sticky wake detection flag |

## Verification
Only one output shows the parser state: the flag. A wrong state, a wrong copy count or a wrong sync count therefore shows up only as a missing or extra flag at the end of a frame. The bench uses frames that stop exactly one copy short, break a copy in the middle, carry extra 0xFF bytes, or end early. These cases turn counter errors into a flag difference within one frame. A fault in the destination filter shows up one frame later, when a wrong address is accepted. The exact-edge test pins down when the flag rises. It catches an extra register stage at the very edge the last copy byte is taken in.

// File: rtl/wol_pkg.sv
package wol_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_DEST = 3'd1,
        ST_SYNC = 3'd2,
        ST_COPY = 3'd3,
        ST_SKIP = 3'd4
    } wol_state_t;

    localparam logic [7:0] SYNC_BYTE = 8'hFF;
endpackage

// File: rtl/wol_mode_ctrl.sv
module wol_mode_ctrl (
    input  logic clk,
    input  logic por_n,
    input  logic pin_en,
    input  logic pwr_good,
    input  logic sw_en,
    input  logic relax_base,
    input  logic ext_relax_wr,
    input  logic ext_relax_din,
    input  logic pattern_hit,
    input  logic da_exact,
    input  logic match_clr,
    output logic wake_mode,
    output logic ext_relax,
    output logic wake_flag
);
    logic accept_dest;

    always_comb begin
        wake_mode   = (pin_en & ~pwr_good) | sw_en;
        accept_dest = relax_base | ext_relax | da_exact;
    end

    // Extended relaxation bit: cleared only by power-on reset.
    always_ff @(posedge clk) begin
        if (!por_n)
            ext_relax <= 1'b0;
        else if (ext_relax_wr)
            ext_relax <= ext_relax_din;
    end

    // Sticky flag: a detection takes priority over a clear.
    always_ff @(posedge clk) begin
        if (!por_n)
            wake_flag <= 1'b0;
        else if (pattern_hit && wake_mode && accept_dest)
            wake_flag <= 1'b1;
        else if (match_clr)
            wake_flag <= 1'b0;
    end

    // R9: the flag holds while no clear is requested
    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!por_n)
        (wake_flag && !match_clr) |=> wake_flag);

    // R6: a rising flag follows a completed pattern seen while armed
    assert_flag_rise_R6: assert property (@(posedge clk) disable iff (!por_n)
        $rose(wake_flag) |-> $past(pattern_hit && wake_mode));

    // R10: the extended bit moves only on a write
    assert_ext_relax_hold_R10: assert property (@(posedge clk) disable iff (!por_n)
        !ext_relax_wr |=> $stable(ext_relax));
endmodule

// File: rtl/wol_dest_filter.sv
module wol_dest_filter #(
    parameter int ADDR_BYTES = 6
) (
    input  logic                    clk,
    input  logic                    por_n,
    input  logic [8*ADDR_BYTES-1:0] station_addr,
    input  logic                    sof_beat,
    input  logic                    dest_beat,
    input  logic [7:0]              dest_byte_ref,
    input  logic [7:0]              rx_byte,
    output logic                    da_exact
);
    always_ff @(posedge clk) begin
        if (!por_n)
            da_exact <= 1'b0;
        else if (sof_beat)
            da_exact <= (rx_byte == station_addr[7:0]);
        else if (dest_beat)
            da_exact <= da_exact & (rx_byte == dest_byte_ref);
    end

    // R2: once a destination byte mismatches, the frame cannot become exact again
    assert_exact_monotonic_R2: assert property (@(posedge clk) disable iff (!por_n)
        (!da_exact && !sof_beat) |=> !da_exact);
endmodule

// File: rtl/wol_pattern_fsm.sv
module wol_pattern_fsm
    import wol_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int SYNC_LEN   = 6,
    parameter int COPIES     = 16
) (
    input  logic                    clk,
    input  logic                    por_n,
    input  logic                    soft_rst,
    input  logic [8*ADDR_BYTES-1:0] station_addr,
    input  logic                    rx_valid,
    input  logic                    rx_sof,
    input  logic                    rx_eof,
    input  logic [7:0]              rx_byte,
    output logic                    sof_beat,
    output logic                    dest_beat,
    output logic [7:0]              dest_byte_ref,
    output logic                    pattern_hit
);
    localparam int PW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
    localparam int CW = (COPIES > 1) ? $clog2(COPIES) : 1;
    localparam int FW = $clog2(SYNC_LEN + 1);
    localparam logic [PW-1:0] POS_LAST  = PW'(ADDR_BYTES - 1);
    localparam logic [CW-1:0] COPY_LAST = CW'(COPIES - 1);
    localparam logic [FW-1:0] FF_LAST   = FW'(SYNC_LEN - 1);

    wol_state_t      st, st_n;
    logic [PW-1:0]   pos, pos_n;
    logic [CW-1:0]   cpy, cpy_n;
    logic [FW-1:0]   ffc, ffc_n;
    logic [7:0]      abyte [ADDR_BYTES];
    logic [7:0]      exp_byte;
    logic            byte_ok;
    logic            is_sync;

    // Split the station address into its wire-order bytes.
    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_bytes
        assign abyte[g] = station_addr[8*g +: 8];
    end

    always_comb begin
        exp_byte = abyte[pos];
        byte_ok  = (rx_byte == exp_byte);
        is_sync  = (rx_byte == SYNC_BYTE);
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            st  <= ST_IDLE;
            pos <= '0;
            cpy <= '0;
            ffc <= '0;
        end else begin
            st  <= st_n;
            pos <= pos_n;
            cpy <= cpy_n;
            ffc <= ffc_n;
        end
    end

    // Next state and outputs.
    always_comb begin
        st_n          = st;
        pos_n         = pos;
        cpy_n         = cpy;
        ffc_n         = ffc;
        pattern_hit   = 1'b0;
        dest_beat     = 1'b0;
        dest_byte_ref = exp_byte;
        sof_beat      = rx_valid & rx_sof & ~soft_rst;
        if (rx_valid && !rx_sof) begin
            unique case (st)
                ST_IDLE: st_n = ST_IDLE;
                ST_DEST: begin
                    dest_beat = 1'b1;
                    if (pos == POS_LAST) begin
                        st_n  = ST_SYNC;
                        pos_n = '0;
                        ffc_n = '0;
                    end else begin
                        pos_n = pos + 1'b1;
                    end
                end
                ST_SYNC: begin
                    if (is_sync) begin
                        if (ffc == FF_LAST) begin
                            st_n  = ST_COPY;
                            pos_n = '0;
                            cpy_n = '0;
                        end else begin
                            ffc_n = ffc + 1'b1;
                        end
                    end else begin
                        ffc_n = '0;
                    end
                end
                ST_COPY: begin
                    if (byte_ok) begin
                        if (pos == POS_LAST) begin
                            pos_n = '0;
                            if (cpy == COPY_LAST) begin
                                pattern_hit = 1'b1;
                                st_n        = ST_SKIP;
                            end else begin
                                cpy_n = cpy + 1'b1;
                            end
                        end else begin
                            pos_n = pos + 1'b1;
                        end
                    end else if (is_sync && pos == '0 && cpy == '0) begin
                        st_n = ST_COPY;
                    end else begin
                        st_n  = ST_SYNC;
                        pos_n = '0;
                        cpy_n = '0;
                        ffc_n = is_sync ? FW'(1) : '0;
                    end
                end
                ST_SKIP: st_n = ST_SKIP;
                default: st_n = ST_IDLE;
            endcase
        end
        if (rx_valid && rx_sof) begin
            st_n  = ST_DEST;
            pos_n = PW'(1);
            cpy_n = '0;
            ffc_n = '0;
        end
        if (rx_valid && rx_eof) begin
            st_n  = ST_IDLE;
            pos_n = '0;
            cpy_n = '0;
            ffc_n = '0;
        end
        if (soft_rst) begin
            st_n        = ST_IDLE;
            pos_n       = '0;
            cpy_n       = '0;
            ffc_n       = '0;
            pattern_hit = 1'b0;
            dest_beat   = 1'b0;
        end
    end

    // R8: an end-of-frame beat returns the parser to idle
    assert_eof_idle_R8: assert property (@(posedge clk) disable iff (!por_n)
        (rx_valid && rx_eof) |=> (st == ST_IDLE));

    // R10: soft reset abandons the frame
    assert_softrst_idle_R10: assert property (@(posedge clk) disable iff (!por_n)
        soft_rst |=> (st == ST_IDLE));

    // R4: the byte position stays inside the address
    assert_pos_range_R4: assert property (@(posedge clk) disable iff (!por_n)
        (pos <= POS_LAST));

    // R6: a completed pattern leaves the copy state
    assert_hit_exit_R6: assert property (@(posedge clk) disable iff (!por_n)
        pattern_hit |=> (st != ST_COPY));
endmodule

// File: rtl/wol_magic_detect.sv
module wol_magic_detect #(
    parameter int ADDR_BYTES = 6,
    parameter int SYNC_LEN   = 6,
    parameter int COPIES     = 16
) (
    input  logic                    clk,
    input  logic                    por_n,
    input  logic                    soft_rst,
    input  logic [8*ADDR_BYTES-1:0] station_addr,
    input  logic                    relax_base,
    input  logic                    ext_relax_wr,
    input  logic                    ext_relax_din,
    input  logic                    pin_en,
    input  logic                    pwr_good,
    input  logic                    sw_en,
    input  logic                    rx_valid,
    input  logic                    rx_sof,
    input  logic                    rx_eof,
    input  logic [7:0]              rx_byte,
    input  logic                    match_clr,
    output logic                    wake_mode,
    output logic                    ext_relax,
    output logic                    wake_flag
);
    logic       sof_beat;
    logic       dest_beat;
    logic [7:0] dest_byte_ref;
    logic       pattern_hit;
    logic       da_exact;

    wol_pattern_fsm #(
        .ADDR_BYTES(ADDR_BYTES),
        .SYNC_LEN  (SYNC_LEN),
        .COPIES    (COPIES)
    ) u_fsm (
        .clk          (clk),
        .por_n        (por_n),
        .soft_rst     (soft_rst),
        .station_addr (station_addr),
        .rx_valid     (rx_valid),
        .rx_sof       (rx_sof),
        .rx_eof       (rx_eof),
        .rx_byte      (rx_byte),
        .sof_beat     (sof_beat),
        .dest_beat    (dest_beat),
        .dest_byte_ref(dest_byte_ref),
        .pattern_hit  (pattern_hit)
    );

    wol_dest_filter #(
        .ADDR_BYTES(ADDR_BYTES)
    ) u_filter (
        .clk          (clk),
        .por_n        (por_n),
        .station_addr (station_addr),
        .sof_beat     (sof_beat),
        .dest_beat    (dest_beat),
        .dest_byte_ref(dest_byte_ref),
        .rx_byte      (rx_byte),
        .da_exact     (da_exact)
    );

    wol_mode_ctrl u_mode (
        .clk          (clk),
        .por_n        (por_n),
        .pin_en       (pin_en),
        .pwr_good     (pwr_good),
        .sw_en        (sw_en),
        .relax_base   (relax_base),
        .ext_relax_wr (ext_relax_wr),
        .ext_relax_din(ext_relax_din),
        .pattern_hit  (pattern_hit),
        .da_exact     (da_exact),
        .match_clr    (match_clr),
        .wake_mode    (wake_mode),
        .ext_relax    (ext_relax),
        .wake_flag    (wake_flag)
    );
endmodule

// File: tb/wol_magic_detect_test.sv
`timescale 1ns/1ps
module wol_magic_detect_test;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic [47:0] station_addr = 48'h917E_553C_1A02;
    logic        relax_base = 1'b0;
    logic        ext_relax_wr = 1'b0;
    logic        ext_relax_din = 1'b0;
    logic        pin_en = 1'b0;
    logic        pwr_good = 1'b1;
    logic        sw_en = 1'b0;
    logic        rx_valid = 1'b0;
    logic        rx_sof = 1'b0;
    logic        rx_eof = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        match_clr = 1'b0;
    logic        wake_mode;
    logic        ext_relax;
    logic        wake_flag;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    wol_magic_detect uut (
        .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .station_addr(station_addr),
        .relax_base(relax_base), .ext_relax_wr(ext_relax_wr), .ext_relax_din(ext_relax_din),
        .pin_en(pin_en), .pwr_good(pwr_good), .sw_en(sw_en),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_byte(rx_byte),
        .match_clr(match_clr), .wake_mode(wake_mode), .ext_relax(ext_relax),
        .wake_flag(wake_flag)
    );

    // da kind: 0 station, 1 other unicast, 2 broadcast, 3 multicast
    // variant: 0 plain, 1 broken copy then full pattern, 2 early end, 3 extra 0xFF
    typedef struct packed {
        logic [1:0] da_kind;
        logic       rb;
        logic       er;
        logic       pe;
        logic       pg;
        logic       se;
        logic [4:0] copies;
        logic [1:0] variant;
        logic       exp_flag;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'd16, 2'd0, 1'b1},
        '{2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'd16, 2'd0, 1'b0},
        '{2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 5'd16, 2'd0, 1'b1},
        '{2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 5'd16, 2'd0, 1'b1},
        '{2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'd15, 2'd0, 1'b0},
        '{2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 5'd16, 2'd0, 1'b0},
        '{2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 5'd16, 2'd0, 1'b1},
        '{2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'd16, 2'd0, 1'b0},
        '{2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'd16, 2'd1, 1'b1},
        '{2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'd16, 2'd2, 1'b0},
        '{2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'd16, 2'd3, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b, input logic s, input logic e);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b; rx_sof = s; rx_eof = e;
    endtask

    task automatic idle_bus(input int n);
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_dest(input logic [1:0] kind, input logic with_sof);
        logic [47:0] d;
        case (kind)
            2'd0: d = station_addr;
            2'd1: d = station_addr ^ 48'h0100_0000_0000;
            2'd2: d = 48'hFFFF_FFFF_FFFF;
            default: d = 48'h0100_005E_0001;
        endcase
        for (int i = 0; i < 6; i++) send(d[8*i +: 8], with_sof && i == 0, 1'b0);
    endtask

    task automatic send_copies(input int n);
        for (int c = 0; c < n; c++)
            for (int i = 0; i < 6; i++) send(station_addr[8*i +: 8], 1'b0, 1'b0);
    endtask

    task automatic send_sync(input int n);
        for (int i = 0; i < n; i++) send(8'hFF, 1'b0, 1'b0);
    endtask

    task automatic send_frame(input logic [1:0] kind, input int copies, input logic [1:0] variant);
        send_dest(kind, 1'b1);
        send(8'h22, 1'b0, 1'b0); send(8'h22, 1'b0, 1'b0); send(8'h08, 1'b0, 1'b0);
        if (variant == 2'd2) begin
            send_sync(6);
            send_copies(9);
            send(8'h02, 1'b0, 1'b1);
        end else begin
            if (variant == 2'd1) begin
                send_sync(6); send_copies(5); send(8'h13, 1'b0, 1'b0);
            end
            send_sync(variant == 2'd3 ? 8 : 6);
            send_copies(copies);
            send(8'h00, 1'b0, 1'b0); send(8'h00, 1'b0, 1'b1);
        end
        idle_bus(2);
    endtask

    task automatic clear_flag();
        @(negedge clk); match_clr = 1'b1;
        @(negedge clk); match_clr = 1'b0;
    endtask

    task automatic write_ext(input logic v);
        @(negedge clk); ext_relax_wr = 1'b1; ext_relax_din = v;
        @(negedge clk); ext_relax_wr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 flag in reset", wake_flag, 0);
        chk("R1 ext_relax in reset", ext_relax, 0);
        por_n = 1'b1;
        @(negedge clk);
        chk("R1 flag after reset", wake_flag, 0);
        chk("R1 ext_relax after reset", ext_relax, 0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            relax_base = VEC[v].rb; pin_en = VEC[v].pe; pwr_good = VEC[v].pg; sw_en = VEC[v].se;
            write_ext(VEC[v].er);
            clear_flag();
            #1 chk($sformatf("R7 wake_mode vec %0d", v), wake_mode,
                   (VEC[v].pe & ~VEC[v].pg) | VEC[v].se);
            send_frame(VEC[v].da_kind, VEC[v].copies, VEC[v].variant);
            chk($sformatf("R2/R3/R4/R5/R6/R8 flag vec %0d", v), wake_flag, VEC[v].exp_flag);
        end

        // R6: exact edge of the flag
        relax_base = 1'b0; pin_en = 1'b0; sw_en = 1'b1; write_ext(1'b0); clear_flag();
        send_dest(2'd0, 1'b1); send_sync(6); send_copies(15);
        for (int i = 0; i < 5; i++) send(station_addr[8*i +: 8], 1'b0, 1'b0);
        send(station_addr[47:40], 1'b0, 1'b0);
        #1 chk("R6 flag before last edge", wake_flag, 0);
        @(posedge clk); #1 chk("R6 flag at last-byte edge", wake_flag, 1);
        // R9: stays set through trailing bytes and idle time
        send(8'h00, 1'b0, 1'b1); idle_bus(5);
        chk("R9 flag sticky", wake_flag, 1);
        clear_flag();
        chk("R9 flag cleared", wake_flag, 0);

        // R8: bytes after end of frame without a new start are ignored
        send_dest(2'd0, 1'b1); send_sync(6); send_copies(3); send(8'h02, 1'b0, 1'b1);
        send_dest(2'd0, 1'b0); send_sync(6); send_copies(16); idle_bus(2);
        chk("R8 no flag without start", wake_flag, 0);

        // R10: soft reset keeps ext_relax and aborts frame
        write_ext(1'b1);
        send_dest(2'd2, 1'b1); send_sync(6); send_copies(8);
        @(negedge clk); rx_valid = 1'b0; soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        send_copies(8); send(8'h00, 1'b0, 1'b1); idle_bus(2);
        chk("R10 soft reset aborts frame", wake_flag, 0);
        chk("R10 ext_relax survives soft reset", ext_relax, 1);
        send_frame(2'd2, 16, 2'd0);
        chk("R3 ext_relax still widens filter", wake_flag, 1);

        // R1: power-on reset clears ext_relax and flag
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        @(negedge clk);
        chk("R1 ext_relax cleared by por", ext_relax, 0);
        chk("R1 flag cleared by por", wake_flag, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule